// File: doc/BRIEF.md
# Software-Acknowledge Resource Controller

This block sits on a destination node and owns a small pool of acknowledge resources. Each resource holds one incoming broadcast message until local software releases it. An arriving message takes the lowest-numbered resource that is fully idle. The resource then shows as pending and its timeout counter starts. Software releases a resource by writing ones to a write-one-to-clear alias. The block sends exactly one reply per message back towards the sender. That reply is a normal one if software released the message in time, or an error one if the timeout expired first.

After a timeout the error reply goes out at once, but the resource stays occupied until software clears its timeout bit. That clear frees the resource and produces no further reply. A control register holds a 4-bit timeout period and a mode enable. The period can only be changed while the mode is off. Once the mode is on, flipping the timebase bit forces a timeout of one chosen resource or of every resource. A timeout raises nothing locally; its only effect is the error reply.

Each resource runs a three-state machine. FREE goes to HELD on allocation. HELD goes to FREE on a software clear, with a normal reply owed. HELD goes to EXPIRED on a periodic or forced timeout, with an error reply owed. EXPIRED goes to FREE on a clear of the timeout bit. The reply port runs a two-state machine. IDLE goes to SEND when any reply is owed, and it latches the lowest owed index. SEND goes back to IDLE when the reply is accepted.

Top module: `swack_resource_ctrl`

## Requirements
- R1: `msg_ready` is high when at least one resource is allocatable, and `alloc_idx` names the lowest such resource. A resource is allocatable only if it is FREE and its reply is neither owed nor waiting on the reply port. An accepted message moves that resource to HELD.
- R2: `status` bit r is 1 while resource r is HELD, and bit N+r is 1 while resource r is EXPIRED. No resource shows both bits.
- R3: A clear write with bit r set on a HELD resource frees it and yields one reply with `rsp_err`=0. Clear bits for FREE resources change nothing.
- R4: With the mode enabled and period P≠0, a HELD resource expires on the P-th prescaled tick after allocation. It sends one reply with `rsp_err`=1 and stays occupied as EXPIRED.
- R5: An EXPIRED resource is freed only by a clear write with bit N+r set, and that release sends no reply. Bit r alone leaves it EXPIRED.
- R6: Control write layout: bits 2:0 select, bit 3 timebase, bits 7:4 period, bit 8 mode enable. The period field is stored only when the stored enable is 0. The enable and timebase bits are always stored.
- R7: While the stored enable is 1, a control write whose bit 3 differs from the stored timebase forces HELD resource `sel` to EXPIRED. A select of 7 forces every HELD resource. A forced select that names a non-HELD resource does nothing.
- R8: With the enable at 0 or the period at 0, no resource ever expires by time.
- R9: `rsp_valid` stays high with a stable `rsp_idx` and `rsp_err` until `rsp_ready`. When several replies are owed, the lowest index goes first.
- R10: After reset every resource is FREE, `status` is 0, `msg_ready` is 1 with `alloc_idx` 0, `rsp_valid` is 0, and the enable and period are 0.
- R11: If a software clear of bit r and a timeout of resource r fall in the same cycle, the clear wins and the reply is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | A resource can take the message |
| alloc_idx | output | IDX_W | Resource the next message will take |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Control write data (sel, timebase, period, enable) |
| clr_we | input | 1 | Clear alias write strobe |
| clr_wdata | input | 2*N | Write-one-to-clear data: pending bits low, timeout bits high |
| status | output | 2*N | Pending bits [N-1:0], timeout bits [2N-1:N] |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply accepted |
| rsp_idx | output | IDX_W | Resource the reply belongs to |
| rsp_err | output | 1 | 1 for a timeout reply, 0 for a normal one |

## Verification
On every cycle the assertions check several things. A stalled reply holds still. An accepted message shows up as pending. The pending and timeout bits never overlap, and a timeout bit only rises from a pending resource. A timeout bit stays set until its own clear bit arrives. Nothing expires while the mode is off. Some behaviour only the bench scenarios can show: the lowest-first order of allocation and replies, the locking of the period, the exact tick on which expiry lands, the single and all-resource forced timeouts, the silence after an expired resource is freed, and the clear winning a tie with a timeout. The bench's cycle-level model confirms these on every clock.

// File: rtl/swack_pkg.sv
package swack_pkg;
    typedef enum logic [1:0] {
        RS_FREE    = 2'd0,
        RS_HELD    = 2'd1,
        RS_EXPIRED = 2'd2
    } res_state_e;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_SEND = 1'b1
    } rsp_state_e;

    // control word layout; select and timebase positions are behavioural
    localparam int CTL_SEL_W   = 3;
    localparam int CTL_TB_BIT  = 3;
    localparam int CTL_PER_LSB = 4;
    localparam int PER_W       = 4;
    localparam int CTL_EN_BIT  = 8;
    localparam int CTL_W       = 9;
    localparam logic [CTL_SEL_W-1:0] SEL_ALL = 3'd7;
endpackage

// File: rtl/swack_ctl_reg.sv
module swack_ctl_reg
    import swack_pkg::*;
#(
    parameter int N        = 8,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic             tick,
    output logic             mode_en,
    output logic [PER_W-1:0] period,
    output logic [N-1:0]     force_vec
);
    localparam int PRESC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PRESC_W-1:0]   presc_q;
    logic                 tb_q;
    logic                 en_q;
    logic [PER_W-1:0]     per_q;
    logic                 flip;
    logic [CTL_SEL_W-1:0] sel;

    assign tick    = (presc_q == PRESC_W'(PRESCALE - 1));
    assign mode_en = en_q;
    assign period  = per_q;
    assign sel     = ctl_wdata[CTL_SEL_W-1:0];
    assign flip    = ctl_we && en_q && (ctl_wdata[CTL_TB_BIT] != tb_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            tb_q    <= 1'b0;
            en_q    <= 1'b0;
            per_q   <= '0;
        end else begin
            presc_q <= tick ? '0 : presc_q + 1'b1;
            if (ctl_we) begin
                if (!en_q) begin
                    per_q <= ctl_wdata[CTL_PER_LSB +: PER_W];
                end
                en_q <= ctl_wdata[CTL_EN_BIT];
                tb_q <= ctl_wdata[CTL_TB_BIT];
            end
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_force
        assign force_vec[r] = flip && ((sel == SEL_ALL) || (sel == CTL_SEL_W'(r)));
    end
endmodule

// File: rtl/swack_slot.sv
module swack_slot
    import swack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mode_en,
    input  logic [PER_W-1:0] period,
    input  logic             force_to,
    input  logic             alloc,
    input  logic             clr_pend,
    input  logic             clr_to,
    input  logic             taken,
    output logic             held,
    output logic             expired,
    output logic             owed,
    output logic             owed_err
);
    res_state_e       st_q, st_d;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic             owed_q, owed_d;
    logic             err_q, err_d;
    logic             expire_now;

    assign expire_now = tick && mode_en && (period != '0) &&
                        (({1'b0, cnt_q} + (PER_W+1)'(1)) >= {1'b0, period});

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        owed_d = owed_q && !taken;
        err_d  = err_q;
        unique case (st_q)
            RS_FREE: begin
                if (alloc) begin
                    st_d  = RS_HELD;
                    cnt_d = '0;
                end
            end
            RS_HELD: begin
                if (clr_pend) begin
                    st_d   = RS_FREE;
                    owed_d = 1'b1;
                    err_d  = 1'b0;
                end else if (force_to || expire_now) begin
                    st_d   = RS_EXPIRED;
                    owed_d = 1'b1;
                    err_d  = 1'b1;
                end else if (tick && (cnt_q != '1)) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RS_EXPIRED: begin
                if (clr_to) begin
                    st_d = RS_FREE;
                end
            end
            default: st_d = RS_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RS_FREE;
            cnt_q  <= '0;
            owed_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            owed_q <= owed_d;
            err_q  <= err_d;
        end
    end

    assign held     = (st_q == RS_HELD);
    assign expired  = (st_q == RS_EXPIRED);
    assign owed     = owed_q;
    assign owed_err = err_q;
endmodule

// File: rtl/swack_reply_arb.sv
module swack_reply_arb
    import swack_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     owed,
    input  logic [N-1:0]     owed_err,
    input  logic             rsp_ready,
    output logic             rsp_valid,
    output logic [IDX_W-1:0] rsp_idx,
    output logic             rsp_err,
    output logic [N-1:0]     take,
    output logic [N-1:0]     inflight
);
    rsp_state_e       st_q, st_d;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] idx_q;
    logic             err_q;
    logic             grant;

    always_comb begin
        pick = '0;
        for (int r = N - 1; r >= 0; r--) begin
            if (owed[r]) begin
                pick = IDX_W'(r);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RP_IDLE: if (|owed)     st_d = RP_SEND;
            RP_SEND: if (rsp_ready) st_d = RP_IDLE;
            default: st_d = RP_IDLE;
        endcase
    end

    assign grant = (st_q == RP_IDLE) && (|owed);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RP_IDLE;
            idx_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (grant) begin
                idx_q <= pick;
                err_q <= owed_err[pick];
            end
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_sel
        assign take[r]     = grant && (pick == IDX_W'(r));
        assign inflight[r] = (st_q == RP_SEND) && (idx_q == IDX_W'(r));
    end

    assign rsp_valid = (st_q == RP_SEND);
    assign rsp_idx   = idx_q;
    assign rsp_err   = err_q;
endmodule

// File: rtl/swack_resource_ctrl.sv
module swack_resource_ctrl
    import swack_pkg::*;
#(
    parameter int  N        = 8,
    parameter int  PRESCALE = 4,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    output logic             msg_ready,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             clr_we,
    input  logic [2*N-1:0]   clr_wdata,
    output logic [2*N-1:0]   status,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [IDX_W-1:0] rsp_idx,
    output logic             rsp_err
);
    logic             tick;
    logic             mode_en;
    logic [PER_W-1:0] period;
    logic [N-1:0]     force_vec;
    logic [N-1:0]     held, expired, owed, owed_err;
    logic [N-1:0]     take, inflight, busy;
    logic             accept;

    swack_ctl_reg #(.N(N), .PRESCALE(PRESCALE)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .tick      (tick),
        .mode_en   (mode_en),
        .period    (period),
        .force_vec (force_vec)
    );

    assign busy = held | expired | owed | inflight;

    always_comb begin
        alloc_idx = '0;
        for (int r = N - 1; r >= 0; r--) begin
            if (!busy[r]) begin
                alloc_idx = IDX_W'(r);
            end
        end
    end

    assign msg_ready = |(~busy);
    assign accept    = msg_valid && msg_ready;

    for (genvar r = 0; r < N; r++) begin : g_slot
        swack_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .mode_en  (mode_en),
            .period   (period),
            .force_to (force_vec[r]),
            .alloc    (accept && (alloc_idx == IDX_W'(r))),
            .clr_pend (clr_we && clr_wdata[r]),
            .clr_to   (clr_we && clr_wdata[N+r]),
            .taken    (take[r]),
            .held     (held[r]),
            .expired  (expired[r]),
            .owed     (owed[r]),
            .owed_err (owed_err[r])
        );
    end

    assign status = {expired, held};

    swack_reply_arb #(.N(N), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .owed      (owed),
        .owed_err  (owed_err),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_idx   (rsp_idx),
        .rsp_err   (rsp_err),
        .take      (take),
        .inflight  (inflight)
    );
endmodule

// File: rtl/swack_resource_ctrl_chk.sv
module swack_resource_ctrl_chk #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             clr_we,
    input logic [2*N-1:0]   clr_wdata,
    input logic [2*N-1:0]   status,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [IDX_W-1:0] rsp_idx,
    input logic             rsp_err,
    input logic             mode_en
);
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_idx) && $stable(rsp_err));

    p_alloc_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> status[$past(alloc_idx)]);

    p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (&(status[N-1:0] | status[2*N-1:N])) |-> !msg_ready);

    for (genvar r = 0; r < N; r++) begin : g_res
        p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(status[r] && status[N+r]));

        p_to_from_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[N+r]) |-> $past(status[r]));

        p_to_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            status[N+r] && !(clr_we && clr_wdata[N+r]) |=> status[N+r]);

        p_no_expiry_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_en && !status[N+r] |=> !status[N+r]);
    end
endmodule

bind swack_resource_ctrl swack_resource_ctrl_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .alloc_idx (alloc_idx),
    .clr_we    (clr_we),
    .clr_wdata (clr_wdata),
    .status    (status),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_idx   (rsp_idx),
    .rsp_err   (rsp_err),
    .mode_en   (mode_en)
);

// File: tb/swack_resource_ctrl_tb.sv
module swack_resource_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int PRESC = 4;
    localparam int WD    = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic [2:0]  alloc_idx;
    logic        ctl_we = 1'b0;
    logic [8:0]  ctl_wdata = '0;
    logic        clr_we = 1'b0;
    logic [15:0] clr_wdata = '0;
    logic [15:0] status;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [2:0]  rsp_idx;
    logic        rsp_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc_n = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc_n++;

    swack_resource_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .alloc_idx(alloc_idx), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .status(status),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_idx(rsp_idx), .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model: 0 free, 1 held, 2 expired
    int m_st[N];
    int m_cnt[N];
    bit m_owed[N];
    bit m_oerr[N];
    int m_presc, m_per, m_ridx;
    bit m_en, m_tb, m_send, m_rerr;

    function automatic bit m_busy(int r);
        return m_st[r] != 0 || m_owed[r] || (m_send && m_ridx == r);
    endfunction
    function automatic int m_aidx();
        for (int r = 0; r < N; r++) if (!m_busy(r)) return r;
        return -1;
    endfunction
    function automatic int m_status();
        int s = 0;
        for (int r = 0; r < N; r++) begin
            if (m_st[r] == 1) s |= (1 << r);
            if (m_st[r] == 2) s |= (1 << (N + r));
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                m_st[r] = 0; m_cnt[r] = 0; m_owed[r] = 0; m_oerr[r] = 0;
            end
            m_presc = 0; m_per = 0; m_en = 0; m_tb = 0; m_send = 0; m_ridx = 0; m_rerr = 0;
        end else begin
            bit tk, flip;
            int sel, aidx, pk;
            tk   = (m_presc == PRESC - 1);
            flip = ctl_we && m_en && (ctl_wdata[3] != m_tb);
            sel  = int'(ctl_wdata[2:0]);
            aidx = m_aidx();
            pk   = -1;
            for (int r = N - 1; r >= 0; r--) if (m_owed[r]) pk = r;
            for (int r = 0; r < N; r++) begin
                bit f;
                f = flip && (sel == 7 || sel == r);
                if (m_st[r] == 0) begin
                    if (msg_valid && aidx == r) begin m_st[r] = 1; m_cnt[r] = 0; end
                end else if (m_st[r] == 1) begin
                    if (clr_we && clr_wdata[r]) begin
                        m_st[r] = 0; m_owed[r] = 1; m_oerr[r] = 0;
                    end else if (f || (tk && m_en && m_per != 0 && m_cnt[r] + 1 >= m_per)) begin
                        m_st[r] = 2; m_owed[r] = 1; m_oerr[r] = 1;
                    end else if (tk && m_cnt[r] < 15) begin
                        m_cnt[r]++;
                    end
                end else begin
                    if (clr_we && clr_wdata[N+r]) m_st[r] = 0;
                end
            end
            if (m_send) begin
                if (rsp_ready) m_send = 0;
            end else if (pk >= 0) begin
                m_send = 1; m_ridx = pk; m_rerr = m_oerr[pk]; m_owed[pk] = 0;
            end
            if (ctl_we) begin
                if (!m_en) m_per = int'(ctl_wdata[7:4]);
                m_en = ctl_wdata[8];
                m_tb = ctl_wdata[3];
            end
            m_presc = tk ? 0 : m_presc + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ai;
            ai = m_aidx();
            check(msg_ready == (ai >= 0), "R1", "model msg_ready", msg_ready, ai >= 0);
            if (ai >= 0) check(alloc_idx == ai, "R1", "model alloc_idx", alloc_idx, ai);
            check(status == 16'(m_status()), "R2", "model status", status, m_status());
            check(rsp_valid == m_send && (!m_send || (rsp_idx == m_ridx && rsp_err == m_rerr)),
                  "R9", "model reply", {rsp_valid, rsp_err, rsp_idx}, {m_send, m_rerr, 3'(m_ridx)});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_alloc(input int exp);
        check(msg_ready && alloc_idx == exp, "R1", "alloc_idx before accept", alloc_idx, exp);
        msg_valid = 1'b1; @(negedge clk); msg_valid = 1'b0;
    endtask
    task automatic wr_ctl(input bit en, input int per, input bit tb, input int sel);
        ctl_we = 1'b1; ctl_wdata = {en, 4'(per), tb, 3'(sel)};
        @(negedge clk); ctl_we = 1'b0;
    endtask
    task automatic wr_clr(input logic [15:0] v);
        clr_we = 1'b1; clr_wdata = v; @(negedge clk); clr_we = 1'b0;
    endtask
    task automatic expect_rsp(input int idx, input bit err, input string tag);
        for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
        check(rsp_valid && rsp_idx == idx && rsp_err == err, tag, "reply idx/err",
              {rsp_valid, rsp_err, rsp_idx}, {1'b1, err, 3'(idx)});
        @(negedge clk);
    endtask
    task automatic expect_quiet(input int n, input string tag);
        bit seen = 0;
        repeat (n) begin
            if (rsp_valid) seen = 1;
            @(negedge clk);
        end
        check(!seen, tag, "no reply expected", seen, 0);
    endtask
    task automatic chk_status(input logic [15:0] exp, input string tag);
        check(status == exp, tag, "status", status, exp);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int t0;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(msg_ready && alloc_idx == 0, "R10", "ready after reset", {msg_ready, alloc_idx}, 4'h8);
        chk_status(16'h0000, "R10");
        check(!rsp_valid, "R10", "rsp_valid after reset", rsp_valid, 0);

        // mode off: allocation, release, no expiry
        do_alloc(0); do_alloc(1); do_alloc(2);
        chk_status(16'h0007, "R2");
        wr_clr(16'h0002);
        expect_rsp(1, 0, "R3");
        chk_status(16'h0005, "R3");
        wr_clr(16'h0020);
        chk_status(16'h0005, "R3");
        expect_quiet(6, "R3");
        do_alloc(1);
        cyc(80);
        chk_status(16'h0007, "R8");
        wr_clr(16'h00FF);
        expect_rsp(0, 0, "R9");
        expect_rsp(1, 0, "R9");
        expect_rsp(2, 0, "R9");

        // period 3, locked; later period write ignored (R6)
        wr_ctl(0, 3, 0, 0);
        wr_ctl(1, 3, 0, 0);
        wr_ctl(1, 15, 0, 0);
        do_alloc(0);
        t0 = cyc_n;
        for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
        check(cyc_n - t0 <= 16, "R6", "expiry delay uses locked period", cyc_n - t0, 16);
        chk_status(16'h0100, "R4");
        expect_rsp(0, 1, "R4");
        cyc(30);
        chk_status(16'h0100, "R4");
        wr_clr(16'h0001);
        chk_status(16'h0100, "R5");
        wr_clr(16'h0100);
        chk_status(16'h0000, "R5");
        expect_quiet(10, "R5");

        // period 0, forced timeouts
        wr_ctl(0, 3, 0, 0);
        wr_ctl(0, 0, 0, 0);
        wr_ctl(1, 0, 0, 0);
        do_alloc(0); do_alloc(1); do_alloc(2);
        cyc(80);
        chk_status(16'h0007, "R8");
        wr_ctl(1, 0, 1, 1);
        chk_status(16'h0205, "R7");
        expect_rsp(1, 1, "R7");
        wr_ctl(1, 0, 0, 5);
        chk_status(16'h0205, "R7");
        expect_quiet(6, "R7");
        rsp_ready = 1'b0;
        wr_ctl(1, 0, 1, 7);
        chk_status(16'h0700, "R7");
        cyc(10);
        check(rsp_valid && rsp_idx == 0 && rsp_err, "R9", "reply held under stall",
              {rsp_valid, rsp_err, rsp_idx}, 5'h18);
        rsp_ready = 1'b1;
        expect_rsp(0, 1, "R9");
        expect_rsp(2, 1, "R9");
        wr_clr(16'h0700);
        chk_status(16'h0000, "R5");
        expect_quiet(8, "R5");

        // clear and forced timeout in the same cycle
        do_alloc(0);
        clr_we = 1'b1; clr_wdata = 16'h0001;
        ctl_we = 1'b1; ctl_wdata = {1'b1, 4'd0, 1'b0, 3'd0};
        @(negedge clk);
        clr_we = 1'b0; ctl_we = 1'b0;
        chk_status(16'h0000, "R11");
        expect_rsp(0, 0, "R11");

        // fill all resources
        for (int r = 0; r < N; r++) do_alloc(r);
        check(!msg_ready, "R1", "ready when full", msg_ready, 0);
        rsp_ready = 1'b0;
        wr_clr(16'h0010);
        cyc(6);
        check(!msg_ready, "R1", "ready while reply in flight", msg_ready, 0);
        chk_status(16'h00EF, "R3");
        rsp_ready = 1'b1;
        expect_rsp(4, 0, "R3");
        check(msg_ready && alloc_idx == 4, "R1", "freed resource allocatable",
              {msg_ready, alloc_idx}, 4'hC);
        wr_clr(16'h00FF);
        cyc(30);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule